// File: doc/BRIEF.md
# Run-Time Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel word of up to nine bits into an asynchronous serial frame on a single output line. The frame shape can be changed while the chip is running. Three plain control inputs set it: a code for the number of data bits, a code for the parity rule and a flag for one or two stop bits. An external divider supplies the bit timing as a one-cycle enable pulse, called the baud tick. Every frame bit begins and ends on that pulse.

Words enter through a valid/ready stream port. `in_ready` is raised only in a baud-tick cycle, and only while the transmitter is idle or is showing the final stop bit of a frame. A word is accepted in a cycle where `in_valid` and `in_ready` are both high. The source may hold `in_valid` high for as long as it needs. The word and its data are not consumed until a handshake cycle happens. Because acceptance can happen during the final stop bit, a held word starts the next frame with no idle gap. The control inputs are captured only at acceptance, so they may change freely while a frame is in flight.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `tx_line` is high and `busy` is low.
- R2: A word is accepted only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only in baud-tick cycles, while the block is idle or is in the final stop bit. From the clock edge of acceptance, `tx_line` drives a low start bit.
- R3: Data bits follow the start bit, beginning with `in_data[0]`. Length code values 0 to 4 on `cfg_len` select 5 to 9 data bits (length = code + 5). Codes 5 to 7 select 9 bits.
- R4: `cfg_parity` code 1 selects odd parity and code 2 selects even parity. Codes 0 and 3 omit the parity bit. When present, the parity bit follows the last data bit. With odd parity, the count of ones over the sent data bits plus the parity bit is odd. With even parity, that count is even.
- R5: The frame ends with high stop bits. `cfg_stop` = 0 gives one stop bit and `cfg_stop` = 1 gives two.
- R6: Each frame bit is held for exactly one baud-tick period. `tx_line` changes only at the clock edge of a baud-tick cycle.
- R7: The data word and all three configuration fields are captured at acceptance. Changes to them during a frame have no effect on that frame.
- R8: `in_ready` stays low from acceptance until the baud-tick cycle that ends the last stop bit, and `busy` stays high over the same span. A word accepted in that final cycle begins its start bit with no idle period in between.
- R9: Bits of `in_data` at or above the selected length are not sent and do not affect the parity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle bit-period enable from the external divider |
| cfg_len | input | 3 | Data length code (bits minus 5; 5 to 7 mean 9) |
| cfg_parity | input | 2 | Parity code: 0 none, 1 odd, 2 even, 3 none |
| cfg_stop | input | 1 | Stop-bit count: 0 one, 1 two |
| in_valid | input | 1 | Source has a word |
| in_ready | output | 1 | Block takes the word in this cycle |
| in_data | input | 9 | Word to send, bit 0 first |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in flight |

## Verification
The start bit appears from the clock edge that accepts the word. Every later bit appears from the edge of the baud-tick cycle that ends the bit before it. A bit is therefore visible throughout the tick cycle that closes it. The bench samples 1 ns after each falling edge and compares the line against the expected bit at every sample within that bit's period, including the closing tick cycle. The idle line and low `busy` are checked one cycle after the final stop tick. For the back-to-back case, the low start bit is expected in that same cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int MIN_BITS   = 5;
  localparam int MAX_BITS   = 9;
  localparam int LEN_CODE_W = 3;
  localparam int PAR_CODE_W = 2;
  localparam int CNT_W      = $clog2(MAX_BITS + 1);
  localparam int CODE_MAX   = MAX_BITS - MIN_BITS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_t;

  typedef enum logic [PAR_CODE_W-1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2,
    PAR_RSVD = 2'd3
  } par_mode_t;

  typedef struct packed {
    logic [CNT_W-1:0] nbits;
    logic             par_en;
    logic             par_odd;
    logic             two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_cfg_dec.sv
module uart_tx_cfg_dec
  import uart_tx_pkg::*;
(
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic [PAR_CODE_W-1:0] par_code,
  input  logic                  stop_code,
  output frame_cfg_t            cfg
);

  par_mode_t mode;

  always_comb begin
    mode = par_mode_t'(par_code);
    if (int'(len_code) >= CODE_MAX)
      cfg.nbits = CNT_W'(MAX_BITS);
    else
      cfg.nbits = CNT_W'(MIN_BITS) + CNT_W'(len_code);
    unique case (mode)
      PAR_ODD:  begin cfg.par_en = 1'b1; cfg.par_odd = 1'b1; end
      PAR_EVEN: begin cfg.par_en = 1'b1; cfg.par_odd = 1'b0; end
      default:  begin cfg.par_en = 1'b0; cfg.par_odd = 1'b0; end
    endcase
    cfg.two_stop = stop_code;
  end

  // R3: decoded length always inside the legal window
  always_comb begin
    p_len_range_r3: assert (int'(cfg.nbits) >= MIN_BITS && int'(cfg.nbits) <= MAX_BITS)
      else $error("decoded length out of range");
  end

endmodule

// File: rtl/uart_tx_capture.sv
module uart_tx_capture
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] data_in,
  input  frame_cfg_t          cfg_in,
  output logic [MAX_BITS-1:0] data_q,
  output frame_cfg_t          cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cfg_q  <= '{nbits: CNT_W'(MIN_BITS), par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b0};
    end else if (load) begin
      data_q <= data_in;
      cfg_q  <= cfg_in;
    end
  end

  // R7: captured word and format hold between acceptances
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(data_q) && $stable(cfg_q)))
    else $error("captured frame state changed without a load");

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
(
  input  logic [MAX_BITS-1:0] data,
  input  logic [CNT_W-1:0]    nbits,
  input  logic                odd,
  output logic                parity_bit
);

  logic [MAX_BITS-1:0] masked;

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign masked[i] = data[i] & (CNT_W'(i) < nbits);
  end

  assign parity_bit = (^masked) ^ odd;

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic                in_valid,
  input  logic [MAX_BITS-1:0] data_q,
  input  frame_cfg_t          cfg_q,
  input  logic                parity_bit,
  output logic                load,
  output logic                in_ready,
  output logic                tx_line,
  output logic                busy
);

  tx_state_t        state;
  logic [CNT_W-1:0] bit_idx;
  logic [CNT_W-1:0] next_idx;
  logic             stop_left;
  logic             last_data;
  logic             stop_end;

  assign next_idx  = bit_idx + CNT_W'(1);
  assign last_data = (bit_idx == (cfg_q.nbits - CNT_W'(1)));
  assign stop_end  = (state == ST_STOP) && !stop_left;
  assign in_ready  = baud_tick && ((state == ST_IDLE) || stop_end);
  assign load      = in_ready && in_valid;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tx_line   <= 1'b1;
      bit_idx   <= '0;
      stop_left <= 1'b0;
    end else if (load) begin
      state   <= ST_START;
      tx_line <= 1'b0;
      bit_idx <= '0;
    end else if (baud_tick) begin
      unique case (state)
        ST_START: begin
          state   <= ST_DATA;
          tx_line <= data_q[0];
          bit_idx <= '0;
        end
        ST_DATA: begin
          if (last_data) begin
            if (cfg_q.par_en) begin
              state   <= ST_PARITY;
              tx_line <= parity_bit;
            end else begin
              state     <= ST_STOP;
              tx_line   <= 1'b1;
              stop_left <= cfg_q.two_stop;
            end
          end else begin
            bit_idx <= next_idx;
            tx_line <= data_q[next_idx];
          end
        end
        ST_PARITY: begin
          state     <= ST_STOP;
          tx_line   <= 1'b1;
          stop_left <= cfg_q.two_stop;
        end
        ST_STOP: begin
          tx_line <= 1'b1;
          if (stop_left) stop_left <= 1'b0;
          else           state     <= ST_IDLE;
        end
        default: begin
          tx_line <= 1'b1;
        end
      endcase
    end
  end

  // R1: idle line rests high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line)
    else $error("line low while idle");

  // R2: acceptance opens a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!tx_line && busy))
    else $error("no start bit after acceptance");

  // R2: ready only offered in tick cycles
  p_ready_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> baud_tick)
    else $error("ready outside a tick cycle");

  // R6: line moves only at tick edges
  p_line_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(tx_line))
    else $error("line changed between ticks");

  // R5: stop period drives high
  p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> tx_line)
    else $error("stop bit not high");

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  baud_tick,
  input  logic [LEN_CODE_W-1:0] cfg_len,
  input  logic [PAR_CODE_W-1:0] cfg_parity,
  input  logic                  cfg_stop,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [MAX_BITS-1:0]   in_data,
  output logic                  tx_line,
  output logic                  busy
);

  frame_cfg_t          cfg_dec;
  frame_cfg_t          cfg_q;
  logic [MAX_BITS-1:0] data_q;
  logic                parity_bit;
  logic                load;

  uart_tx_cfg_dec u_dec (
    .len_code  (cfg_len),
    .par_code  (cfg_parity),
    .stop_code (cfg_stop),
    .cfg       (cfg_dec)
  );

  uart_tx_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .data_in (in_data),
    .cfg_in  (cfg_dec),
    .data_q  (data_q),
    .cfg_q   (cfg_q)
  );

  uart_tx_parity u_par (
    .data       (data_q),
    .nbits      (cfg_q.nbits),
    .odd        (cfg_q.par_odd),
    .parity_bit (parity_bit)
  );

  uart_tx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .in_valid   (in_valid),
    .data_q     (data_q),
    .cfg_q      (cfg_q),
    .parity_bit (parity_bit),
    .load       (load),
    .in_ready   (in_ready),
    .tx_line    (tx_line),
    .busy       (busy)
  );

  // R8: frame in flight right after acceptance, ready withheld
  p_busy_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !in_ready))
    else $error("busy/ready wrong after acceptance");

endmodule

// File: tb/uart_frame_tx_bench.sv
`timescale 1ns/100ps
module uart_frame_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [2:0] cfg_len = '0;
  logic [1:0] cfg_parity = '0;
  logic       cfg_stop = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic       tx_line;
  logic       busy;

  int checks = 0;
  int errors = 0;
  logic [1:0] tick_cnt = '0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt  <= tick_cnt + 2'd1;
    baud_tick <= (tick_cnt == 2'd2);
  end

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .tx_line(tx_line), .busy(busy)
  );

  // entry: {data[8:0], len_code[2:0], par_code[1:0], stop}
  localparam int NVEC = 8;
  localparam logic [14:0] VEC [NVEC] = '{
    {9'h055, 3'd0, 2'd0, 1'b0},
    {9'h0A5, 3'd3, 2'd2, 1'b0},
    {9'h0A5, 3'd3, 2'd1, 1'b1},
    {9'h1FF, 3'd4, 2'd1, 1'b1},
    {9'h000, 3'd3, 2'd1, 1'b0},
    {9'h1E3, 3'd1, 2'd3, 1'b0},
    {9'h12C, 3'd6, 2'd2, 1'b1},
    {9'h07F, 3'd2, 2'd2, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected frame from the requirements; returns bit count
  function automatic int build(input logic [14:0] v, output logic [12:0] bits);
    logic [8:0] d = v[14:6];
    int len = (int'(v[5:3]) >= 4) ? 9 : int'(v[5:3]) + 5;
    int ones = 0;
    int n = 0;
    bits = '1;
    bits[n++] = 1'b0;
    for (int i = 0; i < len; i++) begin
      bits[n++] = d[i];
      ones += int'(d[i]);
    end
    if (v[2:1] == 2'd1) bits[n++] = ((ones % 2) == 0);
    else if (v[2:1] == 2'd2) bits[n++] = ((ones % 2) == 1);
    bits[n++] = 1'b1;
    if (v[0]) bits[n++] = 1'b1;
    return n;
  endfunction

  task automatic present(input logic [14:0] v);
    in_data    = v[14:6];
    cfg_len    = v[5:3];
    cfg_parity = v[2:1];
    cfg_stop   = v[0];
    in_valid   = 1'b1;
  endtask

  // Checks one frame; chain_next presents nxt in the last stop tick cycle
  task automatic run_frame(input logic [14:0] v, input bit accepted,
                           input bit chain_next, input logic [14:0] nxt);
    logic [12:0] bits;
    int n = build(v, bits);
    if (!accepted) begin
      present(v);
      do begin @(negedge clk); #1; end while (!in_ready);
    end
    @(negedge clk); #1;
    in_valid   = 1'b0;
    cfg_len    = ~cfg_len;      // R7: scramble after capture
    cfg_parity = ~cfg_parity;
    cfg_stop   = ~cfg_stop;
    in_data    = ~in_data;
    for (int k = 0; k < n; k++) begin
      bit bad = 0;
      logic seen = 1'b0;
      forever begin
        if (tx_line !== bits[k]) begin bad = 1; seen = tx_line; end
        if (baud_tick) break;
        @(negedge clk); #1;
      end
      // R3 R4 R5 R6 R7 R9: bit value across its whole period
      check($sformatf("R6/R3/R4/R5/R7/R9 bit %0d", k), bad ? 32'(seen) : 32'(bits[k]), 32'(bits[k]));
      if (k < n - 1) begin
        check("R8 ready low in frame", 32'(in_ready), 0);
        check("R8 busy high in frame", 32'(busy), 1);
        @(negedge clk); #1;
      end else begin
        check("R8 ready at last stop tick", 32'(in_ready), 1);
        if (chain_next) present(nxt);
      end
    end
    if (!chain_next) begin
      @(negedge clk); #1;
      check("R1 idle line high after frame", 32'(tx_line), 1);
      check("R1 busy low after frame", 32'(busy), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    do begin @(negedge clk); #1; end while (baud_tick);
    check("R1 reset line high", 32'(tx_line), 1);
    check("R1 reset busy low", 32'(busy), 0);
    check("R2 no ready without tick", 32'(in_ready), 0);
    do begin @(negedge clk); #1; end while (!baud_tick);
    check("R2 ready on idle tick", 32'(in_ready), 1);
    // R2: valid between ticks is not taken
    @(negedge clk); #1;
    present(VEC[0]);
    @(negedge clk); #1;
    check("R2 no accept off tick line", 32'(tx_line), 1);
    check("R2 no accept off tick busy", 32'(busy), 0);

    for (int i = 0; i < NVEC; i++) run_frame(VEC[i], 1'b0, 1'b0, '0);

    // R8: back-to-back frames with no gap
    run_frame(VEC[1], 1'b0, 1'b1, VEC[3]);
    @(posedge clk); #1;
    check("R8 start follows stop with no gap", 32'(tx_line), 0);
    run_frame(VEC[3], 1'b1, 1'b0, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule